// File: doc/BRIEF.md
# Instrument Status Reporting Register Set

This block keeps the status reporting state of a remotely programmable instrument. Single-cycle pulses report errors and completion. They are caught in a sticky standard event register. A programmable enable mask reduces the caught events to one event summary bit. That bit joins three live summary levels in a status byte: channel summary, questionable summary and message available.

A second mask, the service-request enable, selects which status byte bits may ask for service. The OR of the selected bits is the master summary. A rising edge of the master summary latches a request-service flag, which drives the service request output.

Reading is done through ports that the command layer strobes:
- An event register read returns the contents and clears them.
- The status-byte query output always shows the live master summary in bit 6 and changes nothing.
- The serial poll output shows the latched request flag in bit 6, and a poll strobe clears only that flag.
- A clear-all strobe empties the event register and the request flag. It leaves both enable masks as they are.

Top module: `instr_status_top`

## Requirements
- R1: While reset is active, and in the cycle after it is released, the event register read data, the query byte, the poll byte and the service request output are all zero.
- R2: An event pulse on input bit 0 (operation complete), 2 (query error), 3 (device error), 4 (execution error) or 5 (command error) sets the same bit of the event register at that clock edge. The bit stays set until it is cleared.
- R3: An event register read clears the register at that clock edge. A bit whose pulse arrives in the same cycle as the read stays set afterwards.
- R4: Event register bits 1, 6 and 7 always read as zero, and pulses on those inputs have no effect. Status byte bits 0, 1 and 7 always read as zero.
- R5: Status byte bit 2 follows channel summary, bit 3 follows questionable summary and bit 4 follows output-queue-not-empty. Bit 5 is the OR of the event register ANDed with the event enable mask. A mask write takes effect from the next cycle.
- R6: Query byte bit 6 is the master summary: the OR of status byte bits 0 to 5 ANDed with the service-request enable mask. Mask bits 6 and 7 are ignored.
- R7: Poll byte bit 6 is the request flag. A poll strobe clears only that flag at its clock edge.
- R8: The request flag sets at the first clock edge after the master summary rises, and this set wins over a poll or clear-all strobe in the same cycle. The service request output equals the request flag.
- R9: A clear-all strobe clears the event register and the request flag. It leaves both enable masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set_i | input | 8 | Event pulses, one bit per event position |
| chan_sum_i | input | 1 | Channel summary level |
| ques_sum_i | input | 1 | Questionable summary level |
| queue_nonempty_i | input | 1 | Output queue holds data |
| ese_wr_i | input | 1 | Write strobe for the event enable mask |
| ese_wdata_i | input | 8 | Event enable mask data |
| sre_wr_i | input | 1 | Write strobe for the service-request enable mask |
| sre_wdata_i | input | 8 | Service-request enable mask data |
| esr_rd_i | input | 1 | Event register read strobe (clears the register) |
| clear_all_i | input | 1 | Clear-all command strobe |
| poll_i | input | 1 | Serial poll strobe |
| esr_rdata_o | output | 8 | Event register contents |
| stb_query_o | output | 8 | Status byte with master summary in bit 6 |
| stb_poll_o | output | 8 | Status byte with request flag in bit 6 |
| srq_o | output | 1 | Service request |

## Verification
Directed sequences come first, and each targets one distinction:
- Pulses on the unassigned event inputs must change nothing.
- A read that coincides with a pulse must keep the new bit and drop the old ones.
- Writing a service-request mask makes the master summary rise one cycle before the request flag. This separates the live query bit from the latched poll bit.
- A poll must drop only the poll bit 6.
- A clear-all followed by a fresh event must bring the summary back through the unchanged masks.

Random cycles then mix sparse event pulses, toggling summary levels, and occasional reads, polls, clear-alls and mask writes. Collisions between set and clear, and repeated master-summary edges, show up there in many combinations.

// File: rtl/instr_status_pkg.sv
// Package: bit positions and masks shared by the status reporting block.
// Assumes an 8-bit register width; positions are fixed because the
// controller software decodes them.
package instr_status_pkg;
    localparam int SB_W = 8;

    // event register bit positions
    localparam int EV_OPC = 0;
    localparam int EV_QYE = 2;
    localparam int EV_DDE = 3;
    localparam int EV_EXE = 4;
    localparam int EV_CME = 5;

    // status byte bit positions
    localparam int SB_CHAN = 2;
    localparam int SB_QUES = 3;
    localparam int SB_MAV  = 4;
    localparam int SB_ESB  = 5;
    localparam int SB_SRQ  = 6;

    // implemented bits
    localparam logic [SB_W-1:0] EV_USED_MASK =
        (SB_W'(1) << EV_OPC) | (SB_W'(1) << EV_QYE) | (SB_W'(1) << EV_DDE) |
        (SB_W'(1) << EV_EXE) | (SB_W'(1) << EV_CME);
    localparam logic [SB_W-1:0] SRE_USED_MASK = (SB_W'(1) << SB_SRQ) - SB_W'(1);
endpackage

// File: rtl/std_event_reg.sv
// Module: sticky standard event register with its enable mask and summary.
// Assumes event inputs are single-cycle pulses; set has priority over clear.
module std_event_reg
    import instr_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SB_W-1:0] evt_set_i,
    input  logic            rd_i,
    input  logic            clear_all_i,
    input  logic            ese_wr_i,
    input  logic [SB_W-1:0] ese_wdata_i,
    output logic [SB_W-1:0] esr_o,
    output logic            esb_o
);
    logic [SB_W-1:0] esr_q;
    logic [SB_W-1:0] ese_q;
    logic [SB_W-1:0] evt_used;
    logic            clr_now;

    // Only implemented positions are ever set.
    assign evt_used = evt_set_i & EV_USED_MASK;
    assign clr_now  = rd_i | clear_all_i;

    // Event register: clear on read or clear-all, new pulses always land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q <= '0;
        end else begin
            esr_q <= (clr_now ? '0 : esr_q) | evt_used;
        end
    end

    // Event enable mask: written by strobe, untouched by clear-all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ese_q <= '0;
        end else if (ese_wr_i) begin
            ese_q <= ese_wdata_i & EV_USED_MASK;
        end
    end

    assign esr_o = esr_q;
    assign esb_o = |(esr_q & ese_q);

    // every pulsed implemented bit is present after the edge
    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(evt_set_i) & EV_USED_MASK) & ~esr_q) == '0));

    // a clearing strobe without pulses leaves the register empty
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && (evt_set_i == '0)) |=> (esr_q == '0));

    // unassigned event inputs never reach the register
    assert_unused_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_now && ((evt_set_i & EV_USED_MASK) == '0)) |=> $stable(esr_q));

    // clear-all alone keeps the enable mask
    assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all_i && !ese_wr_i) |=> $stable(ese_q));
endmodule

// File: rtl/status_byte_unit.sv
// Module: assembles the status byte, the service-request mask, the master
// summary and the latched request-service flag.
// Assumes summary inputs are levels; the flag latches on a master-summary rise.
module status_byte_unit
    import instr_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chan_i,
    input  logic            ques_i,
    input  logic            mav_i,
    input  logic            esb_i,
    input  logic            poll_i,
    input  logic            clear_all_i,
    input  logic            sre_wr_i,
    input  logic [SB_W-1:0] sre_wdata_i,
    output logic [SB_W-1:0] query_o,
    output logic [SB_W-1:0] poll_o,
    output logic            rqs_o
);
    logic [SB_W-1:0] base;
    logic [SB_W-1:0] sre_q;
    logic            mss;
    logic            mss_q;
    logic            rqs_q;
    logic            mss_rise;

    // Status byte bits below bit 6 from live summaries.
    always_comb begin
        base          = '0;
        base[SB_CHAN] = chan_i;
        base[SB_QUES] = ques_i;
        base[SB_MAV]  = mav_i;
        base[SB_ESB]  = esb_i;
    end

    assign mss      = |(base & sre_q);
    assign mss_rise = mss & ~mss_q;

    // Service-request enable mask: bits 6 and up discarded on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sre_q <= '0;
        end else if (sre_wr_i) begin
            sre_q <= sre_wdata_i & SRE_USED_MASK;
        end
    end

    // Previous master summary for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mss_q <= 1'b0;
        end else begin
            mss_q <= mss;
        end
    end

    // Request flag: set on rise (wins), cleared by poll or clear-all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rqs_q <= 1'b0;
        end else if (mss_rise) begin
            rqs_q <= 1'b1;
        end else if (poll_i || clear_all_i) begin
            rqs_q <= 1'b0;
        end
    end

    // Output bytes differ only in bit 6.
    always_comb begin
        query_o         = base;
        query_o[SB_SRQ] = mss;
        poll_o          = base;
        poll_o[SB_SRQ]  = rqs_q;
    end

    assign rqs_o = rqs_q;

    // rising master summary latches the flag one edge later
    assert_rise_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mss && !mss_q) |=> rqs_q);

    // the flag only ever becomes set after a master-summary rise
    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rqs_q && !(mss && !mss_q)) |=> !rqs_q);

    // poll without a coincident rise drops the flag
    assert_poll_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !(mss && !mss_q)) |=> !rqs_q);

    // clear-all alone keeps the service-request mask
    assert_sre_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all_i && !sre_wr_i) |=> $stable(sre_q));

    // unassigned status positions stay zero
    assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (query_o[1:0] == 2'b00) && (poll_o[SB_W-1] == 1'b0));
endmodule

// File: rtl/instr_status_top.sv
// Module: top of the status reporting register set; wires the event register
// summary into the status byte unit.
// Assumes strobes are single-cycle and synchronous to clk.
module instr_status_top
    import instr_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SB_W-1:0] evt_set_i,
    input  logic            chan_sum_i,
    input  logic            ques_sum_i,
    input  logic            queue_nonempty_i,
    input  logic            ese_wr_i,
    input  logic [SB_W-1:0] ese_wdata_i,
    input  logic            sre_wr_i,
    input  logic [SB_W-1:0] sre_wdata_i,
    input  logic            esr_rd_i,
    input  logic            clear_all_i,
    input  logic            poll_i,
    output logic [SB_W-1:0] esr_rdata_o,
    output logic [SB_W-1:0] stb_query_o,
    output logic [SB_W-1:0] stb_poll_o,
    output logic            srq_o
);
    logic esb;

    // sticky event register and its summary
    std_event_reg u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_set_i   (evt_set_i),
        .rd_i        (esr_rd_i),
        .clear_all_i (clear_all_i),
        .ese_wr_i    (ese_wr_i),
        .ese_wdata_i (ese_wdata_i),
        .esr_o       (esr_rdata_o),
        .esb_o       (esb)
    );

    // status byte, master summary and request flag
    status_byte_unit u_stb (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_i      (chan_sum_i),
        .ques_i      (ques_sum_i),
        .mav_i       (queue_nonempty_i),
        .esb_i       (esb),
        .poll_i      (poll_i),
        .clear_all_i (clear_all_i),
        .sre_wr_i    (sre_wr_i),
        .sre_wdata_i (sre_wdata_i),
        .query_o     (stb_query_o),
        .poll_o      (stb_poll_o),
        .rqs_o       (srq_o)
    );
endmodule

// File: tb/instr_status_top_tb.sv
// Bench: directed corner cases then seeded random cycles against a model
// built from the requirements.
module instr_status_top_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt_set_i, ese_wdata_i, sre_wdata_i;
    logic       chan_sum_i, ques_sum_i, queue_nonempty_i;
    logic       ese_wr_i, sre_wr_i, esr_rd_i, clear_all_i, poll_i;
    logic [7:0] esr_rdata_o, stb_query_o, stb_poll_o;
    logic       srq_o;

    int checks = 0;
    int errors = 0;

    // model state
    logic [7:0] m_esr, m_ese, m_sre;
    logic       m_rqs, m_mss_prev;

    always #2 clk = ~clk;

    instr_status_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i),
        .chan_sum_i(chan_sum_i), .ques_sum_i(ques_sum_i),
        .queue_nonempty_i(queue_nonempty_i), .ese_wr_i(ese_wr_i),
        .ese_wdata_i(ese_wdata_i), .sre_wr_i(sre_wr_i), .sre_wdata_i(sre_wdata_i),
        .esr_rd_i(esr_rd_i), .clear_all_i(clear_all_i), .poll_i(poll_i),
        .esr_rdata_o(esr_rdata_o), .stb_query_o(stb_query_o),
        .stb_poll_o(stb_poll_o), .srq_o(srq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_base();
        logic [7:0] b = 8'h00;
        b[2] = chan_sum_i;
        b[3] = ques_sum_i;
        b[4] = queue_nonempty_i;
        b[5] = |(m_esr & m_ese);
        return b;
    endfunction

    function automatic logic model_mss();
        return |(model_base() & m_sre & 8'h3F);
    endfunction

    // Drive one cycle, check combinational outputs, advance the model.
    task automatic step(input logic [7:0] evt, input logic rd, input logic clr,
                        input logic pl, input logic ew, input logic [7:0] ed,
                        input logic sw, input logic [7:0] sd,
                        input logic ch, input logic qu, input logic mv);
        logic [7:0] b;
        logic       mss;
        @(negedge clk);
        evt_set_i = evt; esr_rd_i = rd; clear_all_i = clr; poll_i = pl;
        ese_wr_i = ew; ese_wdata_i = ed; sre_wr_i = sw; sre_wdata_i = sd;
        chan_sum_i = ch; ques_sum_i = qu; queue_nonempty_i = mv;
        #1;
        b   = model_base();
        mss = model_mss();
        check("R2 R3 R4 event register", esr_rdata_o, m_esr);
        check("R5 R6 query byte", stb_query_o, b | {1'b0, mss, 6'b0});
        check("R7 poll byte", stb_poll_o, b | {1'b0, m_rqs, 6'b0});
        check("R8 service request", {7'b0, srq_o}, {7'b0, m_rqs});
        // next state
        if (mss && !m_mss_prev) m_rqs = 1'b1;
        else if (pl || clr)     m_rqs = 1'b0;
        m_mss_prev = mss;
        m_esr = ((rd || clr) ? 8'h00 : m_esr) | (evt & 8'h3D);
        if (ew) m_ese = ed & 8'h3D;
        if (sw) m_sre = sd & 8'h3F;
    endtask

    task automatic idle();
        step(8'h00, 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
    endtask

    // Literal check just after the edge that ends the previous step.
    task automatic after_edge(input string tag, input logic [7:0] e_esr,
                              input logic [7:0] e_q, input logic [7:0] e_p);
        @(posedge clk);
        #1;
        check(tag, esr_rdata_o, e_esr);
        check(tag, stb_query_o, e_q);
        check(tag, stb_poll_o, e_p);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        evt_set_i = 8'hFF; esr_rd_i = 0; clear_all_i = 0; poll_i = 0;
        ese_wr_i = 1; ese_wdata_i = 8'hFF; sre_wr_i = 1; sre_wdata_i = 8'hFF;
        chan_sum_i = 0; ques_sum_i = 0; queue_nonempty_i = 0;
        m_esr = 0; m_ese = 0; m_sre = 0; m_rqs = 0; m_mss_prev = 0;
        repeat (4) @(posedge clk);
        #1;
        // R1: outputs zero during reset
        check("R1 reset event", esr_rdata_o, 8'h00);
        check("R1 reset query", stb_query_o, 8'h00);
        check("R1 reset poll", stb_poll_o, 8'h00);
        @(negedge clk);
        evt_set_i = 0; ese_wr_i = 0; sre_wr_i = 0; ese_wdata_i = 0; sre_wdata_i = 0;
        rst_n = 1'b1;
        idle();

        // R4: unassigned event inputs ignored
        step(8'hC2, 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R4 unassigned pulses", 8'h00, 8'h00, 8'h00);
        // R2: all assigned positions set and stay
        step(8'h3D, 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R2 pulses latch", 8'h3D, 8'h00, 8'h00);
        idle();
        after_edge("R2 sticky", 8'h3D, 8'h00, 8'h00);
        // R3: read with coincident pulse keeps only the new bit
        step(8'h10, 1, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R3 read with pulse", 8'h10, 8'h00, 8'h00);
        // R5: enable mask takes effect next cycle
        step(8'h00, 0, 0, 0, 1, 8'hFF, 0, 8'h00, 0, 0, 0);
        after_edge("R5 event summary", 8'h10, 8'h20, 8'h20);
        // R6: mask write raises master summary, bits 6-7 of the mask ignored
        step(8'h00, 0, 0, 0, 0, 8'h00, 1, 8'hE0, 0, 0, 0);
        after_edge("R6 master summary", 8'h10, 8'h60, 8'h20);
        // R8: flag follows one edge later
        idle();
        after_edge("R8 request latched", 8'h10, 8'h60, 8'h60);
        // R7: poll clears only bit 6 of the poll byte
        step(8'h00, 0, 0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R7 poll clears flag", 8'h10, 8'h60, 8'h20);
        // R9: clear-all empties register, masks survive
        step(8'h00, 0, 1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R9 clear-all", 8'h00, 8'h00, 8'h00);
        step(8'h10, 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R9 masks kept", 8'h10, 8'h60, 8'h20);
        // R8: set wins over coincident poll on a rise
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step(8'h10, 0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step(8'h00, 0, 0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        after_edge("R8 set beats poll", 8'h10, 8'h60, 8'h60);
        // R5: live level inputs
        step(8'h00, 1, 0, 0, 1, 8'h00, 1, 8'h00, 1, 1, 1);
        after_edge("R5 levels", 8'h00, 8'h1C, 8'h5C);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] ev;
            ev = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            step(ev, ($urandom % 9 == 0), ($urandom % 37 == 0), ($urandom % 7 == 0),
                 ($urandom % 25 == 0), 8'($urandom), ($urandom % 25 == 0), 8'($urandom),
                 ($urandom % 5 == 0) ? 1'($urandom) : chan_sum_i,
                 ($urandom % 5 == 0) ? 1'($urandom) : ques_sum_i,
                 ($urandom % 5 == 0) ? 1'($urandom) : queue_nonempty_i);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule